// File: doc/BRIEF.md
# DMX512 Packet Transmitter and Slot Filter

This block sends and receives DMX512 lighting packets on a single serial line. The bit rate comes from an oversampling tick input: one bit time is `OS_RATE` tick pulses. On the transmit side, the first byte written after reset is sent as a start code. It is preceded by a break and a mark-after-break that the block generates on its own. The following bytes go out as data slots. A count input, loaded with the number of data slots minus one, tells the transmitter when a packet is complete. The next byte written after that begins a new packet, again with an automatic break.

On the receive side, the block measures every low period on the input line. A low that lasts long enough counts as a break. It realigns the slot counter, raises a one-cycle pulse, and marks the next byte as the start code. The start code is always stored. Data slots are stored only when their index falls inside a programmed inclusive window. Stored bytes are placed in a small FIFO, and a sticky flag records any byte lost because the FIFO was full. A line at 250 kbit/s is typical; only the tick rate sets the real speed.

Top module: `dmx_node`

## Requirements
- R1: After reset, `tx_line` is high, `wr_ready` is 1, `rd_valid` is 0, `brk_pulse` is 0 and `ovf_flag` is 0.
- R2: Every packet the transmitter sends starts with `tx_line` low for exactly 25 bit times, where one bit time is `OS_RATE` pulses of `os_tick`.
- R3: Right after the break, `tx_line` is high for exactly 3 bit times, and then the start-code slot begins.
- R4: Each slot is one low start bit, then 8 data bits with the least significant bit first, then two high stop bits.
- R5: A packet carries the start code and then `tx_slots_m1`+1 data slots. The next byte written after the last data slot begins a new packet with its own break. The first byte written after reset also opens a packet.
- R6: A low of at least 23 bit times on `rx_line` is a break and gives exactly one one-cycle `brk_pulse`. A low of 22 bit times gives none.
- R7: The first byte received after a break is always stored, with `rd_start`=1. Every other stored byte has `rd_start`=0.
- R8: Data slots are numbered from 0, starting with the first byte after the start code. A slot is stored only if `win_first` <= index <= `win_last`. All other slots are dropped.
- R9: Until the first break after reset, received bytes are dropped. After a low that ends without a valid stop bit but is shorter than a break, received bytes are also dropped until the next break.
- R10: If a byte to be stored arrives while the FIFO holds `FIFO_DEPTH` entries, that byte is dropped and `ovf_flag` is set. The flag stays set until reset.
- R11: A byte is taken when `wr_valid` and `wr_ready` are both high in the same cycle. `wr_ready` is low in the following cycle and stays low until the byte has moved into the shifter.
- R12: `rd_valid` is high while the FIFO holds data. `rd_data` and `rd_start` show the oldest entry, and `rd_en` with `rd_valid` removes it. Entries leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, `OS_RATE` pulses per bit time |
| tx_slots_m1 | input | CNT_W | Number of data slots per transmitted packet, minus one |
| wr_valid | input | 1 | Write request for a byte to transmit |
| wr_data | input | 8 | Byte to transmit |
| wr_ready | output | 1 | Transmit holding register is free |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| win_first | input | CNT_W | First data slot index to keep (inclusive) |
| win_last | input | CNT_W | Last data slot index to keep (inclusive) |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest stored byte |
| rd_start | output | 1 | Oldest stored byte is a start code |
| rd_valid | output | 1 | FIFO is not empty |
| brk_pulse | output | 1 | One-cycle pulse for each detected break |
| ovf_flag | output | 1 | Sticky flag: a byte was lost to a full FIFO |

## Verification
The transmitter sends a three-slot packet and then one more byte, with the output looped back to the input. A line monitor decodes the output. It checks the width of the break, the width of the mark and the order of the bytes, and so shows whether the second break comes exactly after the programmed count. The same packet is received through a window of slots 1 to 2, which separates the stored start code from kept and dropped data slots. The bench then drives the input directly: bytes with no prior break, a 22-bit low next to an exact 23-bit break with a one-slot window at index 3, and a full-window burst longer than the FIFO. These separate the break threshold, the resynchronisation rule and the overflow path.

// File: rtl/dmx_pkg.sv
// Shared constants and state types for the DMX512 node.
// Assumes one bit time equals OS_RATE oversampling ticks (set at the top).
package dmx_pkg;
    localparam int BREAK_BITS   = 25;  // transmitted break length
    localparam int MAB_BITS     = 3;   // transmitted mark-after-break length
    localparam int BRK_MIN_BITS = 23;  // shortest low accepted as a break
    localparam int FRAME_BITS   = 11;  // start + 8 data + 2 stop
    localparam int DATA_BITS    = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BREAK,
        TX_MAB,
        TX_SLOT
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT
    } rx_state_e;
endpackage

// File: rtl/dmx_tx.sv
// DMX512 transmit engine.
// It holds one written byte. The first byte of a packet is sent as a start
// code after an automatic break and mark-after-break. After that, slots_m1+1
// data slots are sent, and the packet closes.
// Assumes OS_RATE >= 2 and that slots_m1 is stable while a packet is open.
module dmx_tx
    import dmx_pkg::*;
#(
    parameter int OS_RATE = 8,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic [CNT_W-1:0] slots_m1,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             tx_line
);
    localparam int TW = $clog2(OS_RATE);

    tx_state_e        state;
    logic [TW-1:0]    tick_cnt;
    logic [4:0]       bit_cnt;
    logic [10:0]      shreg;
    logic [7:0]       hold_q;
    logic             hold_v;
    logic             pkt_open;
    logic             cur_start;
    logic [CNT_W-1:0] sent;
    logic             bit_end;

    assign wr_ready = !hold_v;
    assign bit_end  = os_tick && (tick_cnt == TW'(OS_RATE - 1));

    // Line level: low during break, shifter LSB during a slot, high otherwise
    always_comb begin
        case (state)
            TX_BREAK: tx_line = 1'b0;
            TX_SLOT:  tx_line = shreg[0];
            default:  tx_line = 1'b1;
        endcase
    end

    // Sequencer: holding register, packet framing and bit timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            tick_cnt  <= '0;
            bit_cnt   <= '0;
            shreg     <= '1;
            hold_q    <= '0;
            hold_v    <= 1'b0;
            pkt_open  <= 1'b0;
            cur_start <= 1'b0;
            sent      <= '0;
        end else begin
            if (wr_valid && !hold_v) begin
                hold_q <= wr_data;
                hold_v <= 1'b1;
            end
            if (os_tick && !bit_end && state != TX_IDLE)
                tick_cnt <= tick_cnt + TW'(1);
            case (state)
                TX_IDLE: begin
                    tick_cnt <= '0;
                    bit_cnt  <= '0;
                    if (hold_v) begin
                        if (!pkt_open) begin
                            state <= TX_BREAK;
                        end else begin
                            shreg     <= {2'b11, hold_q, 1'b0};
                            hold_v    <= 1'b0;
                            cur_start <= 1'b0;
                            state     <= TX_SLOT;
                        end
                    end
                end
                TX_BREAK: begin
                    if (bit_end) begin
                        tick_cnt <= '0;
                        if (bit_cnt == 5'(BREAK_BITS - 1)) begin
                            bit_cnt <= '0;
                            state   <= TX_MAB;
                        end else begin
                            bit_cnt <= bit_cnt + 5'd1;
                        end
                    end
                end
                TX_MAB: begin
                    if (bit_end) begin
                        tick_cnt <= '0;
                        if (bit_cnt == 5'(MAB_BITS - 1)) begin
                            bit_cnt   <= '0;
                            shreg     <= {2'b11, hold_q, 1'b0};
                            hold_v    <= 1'b0;
                            cur_start <= 1'b1;
                            state     <= TX_SLOT;
                        end else begin
                            bit_cnt <= bit_cnt + 5'd1;
                        end
                    end
                end
                default: begin
                    if (bit_end) begin
                        tick_cnt <= '0;
                        shreg    <= {1'b1, shreg[10:1]};
                        if (bit_cnt == 5'(FRAME_BITS - 1)) begin
                            bit_cnt <= '0;
                            state   <= TX_IDLE;
                            if (cur_start) begin
                                pkt_open <= 1'b1;
                                sent     <= '0;
                            end else if (sent == slots_m1) begin
                                pkt_open <= 1'b0;
                            end else begin
                                sent <= sent + CNT_W'(1);
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 5'd1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dmx_rx.sv
// DMX512 receive engine.
// It measures low runs to find breaks, frames slots with mid-bit sampling,
// and produces one store request per start code or per in-window data slot.
// Assumes rx_line is asynchronous (a two-flop synchroniser is used) and
// OS_RATE >= 2.
module dmx_rx
    import dmx_pkg::*;
#(
    parameter int OS_RATE = 8,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rx_line,
    input  logic [CNT_W-1:0] win_first,
    input  logic [CNT_W-1:0] win_last,
    output logic             store,
    output logic [7:0]       store_data,
    output logic             store_start,
    output logic             brk_pulse
);
    localparam int TW        = $clog2(OS_RATE);
    localparam int HALF      = OS_RATE / 2;
    localparam int BRK_TICKS = BRK_MIN_BITS * OS_RATE;
    localparam int LW        = $clog2(BRK_TICKS + 1);

    logic [1:0]       sync_q;
    logic             rx_s;
    logic [LW-1:0]    low_cnt;
    logic             brk_hit;
    rx_state_e        state;
    logic [TW-1:0]    tick_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             synced;
    logic             expect_sc;
    logic [CNT_W-1:0] slot_idx;
    logic             in_win;

    assign rx_s    = sync_q[1];
    assign brk_hit = os_tick && !rx_s && (low_cnt == LW'(BRK_TICKS - 1));
    assign in_win  = (slot_idx >= win_first) && (slot_idx <= win_last);

    // Two-flop synchroniser, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    // Low-run length in ticks, saturating at the break threshold
    always_ff @(posedge clk) begin
        if (!rst_n || rx_s)                          low_cnt <= '0;
        else if (os_tick && low_cnt != LW'(BRK_TICKS)) low_cnt <= low_cnt + LW'(1);
    end

    // One-cycle break indication
    always_ff @(posedge clk) begin
        if (!rst_n) brk_pulse <= 1'b0;
        else        brk_pulse <= brk_hit;
    end

    // Slot framing, slot counting and store decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            tick_cnt    <= '0;
            bit_cnt     <= '0;
            shreg       <= '0;
            synced      <= 1'b0;
            expect_sc   <= 1'b0;
            slot_idx    <= '0;
            store       <= 1'b0;
            store_data  <= '0;
            store_start <= 1'b0;
        end else begin
            store <= 1'b0;
            if (brk_hit) begin
                state     <= RX_WAIT;
                synced    <= 1'b1;
                expect_sc <= 1'b1;
            end else begin
                case (state)
                    RX_IDLE: begin
                        tick_cnt <= '0;
                        if (os_tick && !rx_s) state <= RX_START;
                    end
                    RX_START: begin
                        if (os_tick) begin
                            if (tick_cnt == TW'(HALF - 1)) begin
                                tick_cnt <= '0;
                                bit_cnt  <= '0;
                                state    <= rx_s ? RX_IDLE : RX_DATA;
                            end else begin
                                tick_cnt <= tick_cnt + TW'(1);
                            end
                        end
                    end
                    RX_DATA: begin
                        if (os_tick) begin
                            if (tick_cnt == TW'(OS_RATE - 1)) begin
                                tick_cnt <= '0;
                                shreg    <= {rx_s, shreg[7:1]};
                                if (bit_cnt == 3'(DATA_BITS - 1)) state <= RX_STOP;
                                else bit_cnt <= bit_cnt + 3'd1;
                            end else begin
                                tick_cnt <= tick_cnt + TW'(1);
                            end
                        end
                    end
                    RX_STOP: begin
                        if (os_tick) begin
                            if (tick_cnt == TW'(OS_RATE - 1)) begin
                                tick_cnt <= '0;
                                if (rx_s) begin
                                    state <= RX_IDLE;
                                    if (synced) begin
                                        store_data <= shreg;
                                        if (expect_sc) begin
                                            store       <= 1'b1;
                                            store_start <= 1'b1;
                                            expect_sc   <= 1'b0;
                                            slot_idx    <= '0;
                                        end else begin
                                            store       <= in_win;
                                            store_start <= 1'b0;
                                            if (slot_idx != '1)
                                                slot_idx <= slot_idx + CNT_W'(1);
                                        end
                                    end
                                end else begin
                                    state  <= RX_WAIT;
                                    synced <= 1'b0;
                                end
                            end else begin
                                tick_cnt <= tick_cnt + TW'(1);
                            end
                        end
                    end
                    default: begin
                        if (rx_s) state <= RX_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dmx_fifo.sv
// Small first-in first-out store for received entries.
// A push while full is ignored (the caller flags it). A pop while empty is
// ignored. Assumes DEPTH is a power of two and at least 2.
module dmx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign head  = mem[rd_ptr[AW-1:0]];

    // Storage write
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + (AW+1)'(1);
            if (pop && !empty) rd_ptr <= rd_ptr + (AW+1)'(1);
        end
    end
endmodule

// File: rtl/dmx_node.sv
// DMX512 node: packet transmitter plus break-aligned, windowed receiver.
// Received start codes and in-window slots go to a FIFO. A sticky flag
// records entries lost to a full FIFO.
// Assumes one bit time = OS_RATE pulses of os_tick.
module dmx_node #(
    parameter int OS_RATE    = 8,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic [CNT_W-1:0] tx_slots_m1,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             tx_line,
    input  logic             rx_line,
    input  logic [CNT_W-1:0] win_first,
    input  logic [CNT_W-1:0] win_last,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_start,
    output logic             rd_valid,
    output logic             brk_pulse,
    output logic             ovf_flag
);
    logic       store;
    logic [7:0] store_data;
    logic       store_start;
    logic [8:0] head;
    logic       empty;
    logic       full;

    dmx_tx #(.OS_RATE(OS_RATE), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .slots_m1 (tx_slots_m1),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .tx_line  (tx_line)
    );

    dmx_rx #(.OS_RATE(OS_RATE), .CNT_W(CNT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_line     (rx_line),
        .win_first   (win_first),
        .win_last    (win_last),
        .store       (store),
        .store_data  (store_data),
        .store_start (store_start),
        .brk_pulse   (brk_pulse)
    );

    dmx_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (store),
        .push_data ({store_start, store_data}),
        .pop       (rd_en),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    assign rd_valid = !empty;
    assign rd_start = head[8];
    assign rd_data  = head[7:0];

    // Sticky overflow: a store request met a full FIFO
    always_ff @(posedge clk) begin
        if (!rst_n)            ovf_flag <= 1'b0;
        else if (store && full) ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/dmx_node_sva.sv
// Property checker for dmx_node, attached with bind. It watches only ports.
// A counter bounds the transmitted low run instead of a long $past window.
module dmx_node_sva #(
    parameter int OS_RATE = 8
) (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic wr_valid,
    input logic wr_ready,
    input logic tx_line,
    input logic rd_en,
    input logic rd_valid,
    input logic brk_pulse,
    input logic ovf_flag
);
    localparam int TXB_TICKS = 25 * OS_RATE;
    localparam int CW        = $clog2(TXB_TICKS + 2);

    logic [CW-1:0] tx_low_ticks;

    // Count consecutive low ticks on the transmit line, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || tx_line)                                  tx_low_ticks <= '0;
        else if (os_tick && tx_low_ticks != CW'(TXB_TICKS + 1)) tx_low_ticks <= tx_low_ticks + CW'(1);
    end

    assert_break_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_low_ticks <= CW'(TXB_TICKS));

    assert_single_brk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_wr_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    assert_data_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> rd_valid);
endmodule

bind dmx_node dmx_node_sva #(.OS_RATE(OS_RATE)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .tx_line   (tx_line),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .brk_pulse (brk_pulse),
    .ovf_flag  (ovf_flag)
);

// File: tb/dmx_node_test.sv
// Bench for dmx_node. A behavioural line monitor decodes tx_line into events.
// Queues hold the expected FIFO contents, which are compared on every pop.
module dmx_node_test;
    localparam int OS    = 8;
    localparam int BT    = OS;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b1;
    logic [15:0] tx_slots_m1 = '0;
    logic [15:0] win_first = '0;
    logic [15:0] win_last = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        tx_line;
    logic        loop_en = 1'b0;
    logic        rx_drv = 1'b1;
    logic        rx_line;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_start;
    logic        rd_valid;
    logic        brk_pulse;
    logic        ovf_flag;

    int checks = 0;
    int fails = 0;
    int brk_seen = 0;
    bit done = 0;
    int ev_q[$];
    int exp_rx[$];

    always #10 clk = ~clk;
    assign rx_line = loop_en ? tx_line : rx_drv;

    dmx_node #(.OS_RATE(OS), .CNT_W(16), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .tx_slots_m1(tx_slots_m1),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .tx_line(tx_line),
        .rx_line(rx_line), .win_first(win_first), .win_last(win_last), .rd_en(rd_en),
        .rd_data(rd_data), .rd_start(rd_start), .rd_valid(rd_valid),
        .brk_pulse(brk_pulse), .ovf_flag(ovf_flag)
    );

    // Count break pulses away from the active edge
    always @(negedge clk) if (rst_n && brk_pulse) brk_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Line monitor: breaks as 1000+len, marks as 2000+len, bytes as value
    bit pend = 0;
    initial begin : tx_mon
        int b;
        int t;
        int h;
        forever begin
            if (!pend) begin
                @(negedge clk);
                while (tx_line !== 1'b0) @(negedge clk);
            end
            pend = 0;
            repeat (BT/2) @(negedge clk);
            b = 0;
            for (int i = 0; i < 10; i++) begin
                repeat (BT) @(negedge clk);
                if (tx_line === 1'b1) b = b | (1 << i);
            end
            if (b == 0) begin
                t = BT/2 + 10*BT + 1;
                forever begin
                    @(negedge clk);
                    if (tx_line === 1'b0) t++; else break;
                end
                ev_q.push_back(1000 + t);
                h = 1;
                forever begin
                    @(negedge clk);
                    if (tx_line === 1'b1) h++; else break;
                end
                ev_q.push_back(2000 + h);
                pend = 1;
            end else if ((b >> 8) == 3) begin
                ev_q.push_back(b & 255);
            end else begin
                ev_q.push_back(3000 + b);
            end
        end
    end

    task automatic send_wr(input logic [7:0] v);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drive(input logic v, input int bits);
        rx_drv = v;
        repeat (bits*BT) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        drive(1'b0, 1);
        for (int i = 0; i < 8; i++) drive(v[i], 1);
        drive(1'b1, 2);
    endtask

    task automatic drain(input string req);
        int e;
        repeat (6) @(negedge clk);
        while (rd_valid) begin
            if (exp_rx.size() == 0) chk(req, {23'd0, rd_start, rd_data}, -1);
            else begin
                e = exp_rx.pop_front();
                chk(req, {23'd0, rd_start, rd_data}, e);
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(req, exp_rx.size(), 0);
        exp_rx.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int exp_ev[$];
        string lbl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_line", tx_line, 1);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 brk_pulse", brk_pulse, 0);
        chk("R1 ovf_flag", ovf_flag, 0);

        // R9: bytes before any break are dropped
        win_first = 16'd0; win_last = 16'd511;
        send_byte(8'h33);
        send_byte(8'h44);
        drain("R9 pre-break");
        chk("R9 no break", brk_seen, 0);

        // R2 R3 R4 R5 transmit, looped back through window 1..2 (R7 R8)
        tx_slots_m1 = 16'd2;
        win_first = 16'd1; win_last = 16'd2;
        loop_en = 1'b1;
        send_wr(8'h00);
        chk("R11 wr_ready held low", wr_ready, 0);
        send_wr(8'hA5);
        send_wr(8'h3C);
        send_wr(8'h81);
        send_wr(8'h11);
        for (int i = 0; i < 6000 && ev_q.size() < 9; i++) @(negedge clk);
        exp_ev = '{1200, 2024, 0, 165, 60, 129, 1200, 2024, 17};
        for (int i = 0; i < 9; i++) begin
            lbl = (i == 6) ? "R5 second break" : (i == 0) ? "R2 break" :
                  (i == 1 || i == 7) ? "R3 mark" : "R4 slot";
            if (ev_q.size() == 0) chk(lbl, -1, exp_ev[i]);
            else chk(lbl, ev_q.pop_front(), exp_ev[i]);
        end
        exp_rx = '{256 + 8'h00, 8'h3C, 8'h81, 256 + 8'h11};
        drain("R8 loopback window");
        chk("R6 two breaks", brk_seen, 2);
        chk("R10 no overflow", ovf_flag, 0);
        loop_en = 1'b0;
        repeat (40) @(negedge clk);

        // R6 R9: 22-bit low is no break and drops later bytes
        win_first = 16'd0; win_last = 16'd511;
        drive(1'b0, 22);
        drive(1'b1, 3);
        send_byte(8'h5A);
        send_byte(8'h10);
        drain("R9 short low");
        chk("R6 short low no pulse", brk_seen, 2);

        // R6 R7 R8: exact 23-bit break, window holds only slot 3
        win_first = 16'd3; win_last = 16'd3;
        drive(1'b0, 23);
        drive(1'b1, 3);
        send_byte(8'h5A);
        send_byte(8'h10);
        send_byte(8'h20);
        send_byte(8'h30);
        send_byte(8'h40);
        send_byte(8'h50);
        exp_rx = '{256 + 8'h5A, 8'h40};
        drain("R7 start and R8 slot 3");
        chk("R6 threshold pulse", brk_seen, 3);

        // R10 R12: overflow with full window, no reads
        win_first = 16'd0; win_last = 16'd511;
        drive(1'b0, 25);
        drive(1'b1, 3);
        send_byte(8'h77);
        for (int i = 1; i <= 5; i++) send_byte(8'(i));
        repeat (6) @(negedge clk);
        chk("R10 overflow set", ovf_flag, 1);
        exp_rx = '{256 + 8'h77, 1, 2, 3};
        drain("R12 order after overflow");
        chk("R10 overflow sticky", ovf_flag, 1);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule